// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects nine interrupt pins from outside the chip and turns them into one request, with a vector number, for the CPU. One pin is non-maskable. The other eight are maskable lines numbered 0 to 7. Every pin passes through a two-flop synchroniser. Each maskable line then goes through a detector that software sets to one of four sense modes. A detection sets a sticky status flag, and only a software write clears it. A line asks for service when its flag and its enable bit are both set. The non-maskable pin has one polarity bit and cannot be masked.

An arbiter picks the winner and registers it. The non-maskable pin always comes first. Among the maskable lines, the one with the higher programmed level wins, and on equal levels the lower-numbered line wins. The arbiter holds the request and its vector until the CPU pulses acknowledge. A small register bus gives access to the sense modes, the enables, the polarity and standby selects, the priority levels and the status flags. A wake output tells the power controller to leave standby. Lines 0 to 2 can always wake the part. Lines 3 to 7 can wake it only while a select bit is set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, req_o is 0 and every register reads 0: all lines in low-level mode, disabled, priority 0, flags clear, non-maskable polarity falling, standby select off.
- R2: Line n takes its sense mode from bits [2n+1:2n] at address 0. The encoding is 00 low level, 01 falling edge, 10 rising edge, 11 either edge. A matching pin event sets flag n, at bit n of address 3. An edge of the other polarity does not set it.
- R3: Writing address 3 clears each flag whose data bit is 0 and leaves alone each flag whose bit is 1. Writing 1 never sets a flag. In low-level mode, a flag cleared while its pin is still low is set again at once.
- R4: Bits [7:0] at address 1 enable lines 0 to 7. A flag on a disabled line stays readable but raises no request until the line is enabled.
- R5: The level of line n is at bits [2n+1:2n] of address 2. The higher level wins, and on equal levels the lower line number wins.
- R6: The non-maskable pin raises vector 7 regardless of the enables. It wins over any maskable line. Bit 8 at address 1 picks its edge: 0 falling, 1 rising.
- R7: Line n is presented as vector 16+n. req_o and vec_o hold until ack_i is seen high at a clock edge, and req_o is 0 after that edge.
- R8: wake_o is high while the non-maskable event is pending or an enabled line 0 to 2 has its flag set. Enabled lines 3 to 7 drive wake_o only while bit 9 at address 1 is 1.
- R9: After a pin change, the flag reads back set after the third rising clock edge, and req_o rises at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| irq_i | input | 8 | Maskable interrupt pins, bit n is line n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector number of the presented request |
| ack_i | input | 1 | Acknowledge pulse from the CPU |
| wake_o | output | 1 | Wake-up from standby |

## Verification
A pin change passes through two synchroniser stages and one flag register. Its status bit therefore reads set only after the third rising edge, wake_o follows at the same point, and the request shows up on the fourth edge. A request drops on the edge that samples acknowledge, and the next winner can be latched one edge later. The bench changes inputs at falling edges, counts falling edges to step past each of those register stages, and samples just after a falling edge, with read data settled. Its service routine checks each presented vector against the queue of expected vectors, in order. It clears the flag while the request is still held and only then acknowledges, so a stale flag cannot raise a second request.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int ADDR_SENSE = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_PRIO  = 2;
  localparam int ADDR_FLAG  = 3;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int          W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_i;
  end

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  hit_o = ~pin_i;
      SENSE_FALL: hit_o = prev_q & ~pin_i;
      SENSE_RISE: hit_o = ~prev_q & pin_i;
      default:    hit_o = prev_q ^ pin_i;
    endcase
  end
endmodule

// File: rtl/eirq_arb.sv
module eirq_arb #(
  parameter int N        = 8,
  parameter int PW       = 2,
  parameter int VW       = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nmi_pend_i,
  input  logic [N-1:0]  cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [VW-1:0] vec_o,
  output logic          nmi_ack_o
);
  logic          found;
  int            best_idx;
  logic [PW-1:0] best_p;
  logic          req_q, is_nmi_q;
  logic [VW-1:0] vec_q;

  // strict compare keeps the lower index on equal levels
  always_comb begin
    found    = 1'b0;
    best_idx = 0;
    best_p   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found || prio_i[i*PW +: PW] > best_p)) begin
        found    = 1'b1;
        best_idx = i;
        best_p   = prio_i[i*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      is_nmi_q <= 1'b0;
      vec_q    <= '0;
    end else if (req_q) begin
      if (ack_i) begin
        req_q    <= 1'b0;
        is_nmi_q <= 1'b0;
      end
    end else if (nmi_pend_i) begin
      req_q    <= 1'b1;
      is_nmi_q <= 1'b1;
      vec_q    <= VW'(NMI_VEC);
    end else if (found) begin
      req_q    <= 1'b1;
      vec_q    <= VW'(VEC_BASE + best_idx);
    end
  end

  assign req_o     = req_q;
  assign vec_o     = vec_q;
  assign nmi_ack_o = req_q & ack_i & is_nmi_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int PRIO_W   = 2,
  parameter int VEC_W    = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 16,
  parameter int WAKE_LO  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              wake_o
);
  localparam int SW       = 2 * N_IRQ;
  localparam int PWALL    = PRIO_W * N_IRQ;
  localparam int BIT_NRISE = N_IRQ;
  localparam int BIT_WSEL  = N_IRQ + 1;

  logic [SW-1:0]    sense_q;
  logic [N_IRQ-1:0] en_q, flag_q, hit, clr, wake_mask;
  logic [PWALL-1:0] prio_q;
  logic             nmi_rise_q, wake_sel_q, nmi_pend_q;
  logic             nmi_s, nmi_hit, nmi_ack;
  logic [N_IRQ-1:0] irq_s;

  wire wr_sense = reg_we_i && reg_addr_i == ADDR_W'(ADDR_SENSE);
  wire wr_ctrl  = reg_we_i && reg_addr_i == ADDR_W'(ADDR_CTRL);
  wire wr_prio  = reg_we_i && reg_addr_i == ADDR_W'(ADDR_PRIO);
  wire wr_flag  = reg_we_i && reg_addr_i == ADDR_W'(ADDR_FLAG);

  eirq_sync #(.W(N_IRQ + 1), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({nmi_i, irq_i}), .q_o({nmi_s, irq_s})
  );

  for (genvar n = 0; n < N_IRQ; n++) begin : g_line
    eirq_detect u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(irq_s[n]),
      .mode_i(sense_e'(sense_q[2*n +: 2])), .hit_o(hit[n])
    );
    assign wake_mask[n] = (n < WAKE_LO) ? 1'b1 : wake_sel_q;
  end

  eirq_detect u_nmi_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(nmi_s),
    .mode_i(nmi_rise_q ? SENSE_RISE : SENSE_FALL), .hit_o(nmi_hit)
  );

  assign clr = wr_flag ? ~reg_wdata_i[N_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q    <= '0;
      en_q       <= '0;
      prio_q     <= '0;
      nmi_rise_q <= 1'b0;
      wake_sel_q <= 1'b0;
      flag_q     <= '0;
      nmi_pend_q <= 1'b0;
    end else begin
      if (wr_sense) sense_q <= reg_wdata_i[SW-1:0];
      if (wr_prio)  prio_q  <= reg_wdata_i[PWALL-1:0];
      if (wr_ctrl) begin
        en_q       <= reg_wdata_i[N_IRQ-1:0];
        nmi_rise_q <= reg_wdata_i[BIT_NRISE];
        wake_sel_q <= reg_wdata_i[BIT_WSEL];
      end
      // detection wins over a clear in the same cycle
      flag_q     <= (flag_q & ~clr) | hit;
      nmi_pend_q <= (nmi_pend_q & ~nmi_ack) | nmi_hit;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_W'(ADDR_SENSE): reg_rdata_o[SW-1:0] = sense_q;
      ADDR_W'(ADDR_CTRL): begin
        reg_rdata_o[N_IRQ-1:0] = en_q;
        reg_rdata_o[BIT_NRISE] = nmi_rise_q;
        reg_rdata_o[BIT_WSEL]  = wake_sel_q;
      end
      ADDR_W'(ADDR_PRIO): reg_rdata_o[PWALL-1:0] = prio_q;
      default:            reg_rdata_o[N_IRQ-1:0] = flag_q;
    endcase
  end

  eirq_arb #(
    .N(N_IRQ), .PW(PRIO_W), .VW(VEC_W), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
  ) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_pend_i(nmi_pend_q),
    .cand_i(flag_q & en_q), .prio_i(prio_q), .ack_i(ack_i),
    .req_o(req_o), .vec_o(vec_o), .nmi_ack_o(nmi_ack)
  );

  assign wake_o = nmi_pend_q | (|(flag_q & en_q & wake_mask));
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int N        = 8,
  parameter int VW       = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ack_i,
  input logic [VW-1:0] vec_i,
  input logic          nmi_pend_i,
  input logic [N-1:0]  flag_i,
  input logic [N-1:0]  en_i,
  input logic          wake_i
);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> req_i && $stable(vec_i));

  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ack_i |=> !req_i);

  assert_vec_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (vec_i == VW'(NMI_VEC)) ||
              (vec_i >= VW'(VEC_BASE) && vec_i < VW'(VEC_BASE + N)));

  assert_nmi_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) && $past(nmi_pend_i) |-> vec_i == VW'(NMI_VEC));

  assert_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) && vec_i != VW'(NMI_VEC) |-> $past(flag_i & en_i) != '0);

  assert_wake_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_pend_i && (flag_i & en_i) == '0 |-> !wake_i);
endmodule

bind ext_irq_ctrl eirq_chk #(
  .N(N_IRQ), .VW(VEC_W), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_o), .ack_i(ack_i),
  .vec_i(vec_o), .nmi_pend_i(nmi_pend_q), .flag_i(flag_q),
  .en_i(en_q), .wake_i(wake_o)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  import eirq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 1'b1;
  logic [7:0]  irq = 8'hFF;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req, ack = 1'b0, wake;
  logic [7:0]  vec;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];
  logic [15:0] sense_v = '0, prio_v = '0, ctrl_v = '0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_i(irq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_o(req), .ack_i(ack), .vec_o(vec),
    .wake_o(wake)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [15:0] d);
    we = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    addr = 2'(a);
    #1;
    d = rdata;
  endtask

  task automatic set_sense(int n, sense_e m);
    sense_v[2*n +: 2] = m;
    wr(ADDR_SENSE, sense_v);
  endtask

  task automatic set_prio(int n, int p);
    prio_v[2*n +: 2] = 2'(p);
    wr(ADDR_PRIO, prio_v);
  endtask

  task automatic push(int v);
    exp_q.push_back(v);
  endtask

  // monitor: wait for a request, compare with queue head, clear, acknowledge
  task automatic service(string tag);
    int w = 0;
    int e;
    while (!req && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " request seen"}, int'(req), 1);
    if (!req) return;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
    chk({tag, " vector"}, int'(vec), e);
    if (vec != 8'd7) wr(ADDR_FLAG, ~(16'd1 << (vec - 8'd16)));
    chk("R7 vector held before ack", int'(vec), e);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R7 req low after ack", int'(req), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    chk("R1 req_o", int'(req), 0);
    chk("R1 wake_o", int'(wake), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, rv);
      chk("R1 register reset", int'(rv), 0);
    end

    ctrl_v = 16'h00FF;
    wr(ADDR_CTRL, ctrl_v);

    // R2 falling edge on line 2 with R9 latency
    set_sense(2, SENSE_FALL);
    irq[2] = 1'b0;
    step(2);
    rd(ADDR_FLAG, rv);
    chk("R9 flag not yet after 2 edges", int'(rv[2]), 0);
    step(1);
    rd(ADDR_FLAG, rv);
    chk("R9 flag set after 3 edges", int'(rv[2]), 1);
    chk("R9 req not yet after 3 edges", int'(req), 0);
    step(1);
    chk("R9 req after 4 edges", int'(req), 1);
    push(18);
    service("R2 falling line2");
    irq[2] = 1'b1;
    step(4);

    // R2 rising edge on line 5
    set_sense(5, SENSE_RISE);
    irq[5] = 1'b0;
    step(5);
    rd(ADDR_FLAG, rv);
    chk("R2 rising mode ignores fall", int'(rv[5]), 0);
    irq[5] = 1'b1;
    push(21);
    service("R2 rising line5");

    // R2 both edges on line 1
    set_sense(1, SENSE_BOTH);
    irq[1] = 1'b0;
    push(17);
    service("R2 both-edge fall line1");
    irq[1] = 1'b1;
    push(17);
    service("R2 both-edge rise line1");

    // R3 low level on line 0 (mode 00), clear while still low
    set_sense(0, SENSE_LOW);
    irq[0] = 1'b0;
    step(4);
    wr(ADDR_FLAG, 16'hFFFE);
    rd(ADDR_FLAG, rv);
    chk("R3 level flag re-set while low", int'(rv[0]), 1);
    irq[0] = 1'b1;
    step(3);
    push(16);
    service("R3 level line0");
    step(2);
    wr(ADDR_FLAG, 16'hFFFF);
    rd(ADDR_FLAG, rv);
    chk("R3 writing ones sets nothing", int'(rv), 0);

    // R4 masking on line 4
    set_sense(4, SENSE_FALL);
    ctrl_v[4] = 1'b0;
    wr(ADDR_CTRL, ctrl_v);
    irq[4] = 1'b0;
    step(6);
    chk("R4 masked line raises no req", int'(req), 0);
    rd(ADDR_FLAG, rv);
    chk("R4 masked flag visible", int'(rv[4]), 1);
    ctrl_v[4] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    push(20);
    service("R4 unmasked line4");
    irq[4] = 1'b1;
    step(4);

    // R5 higher level wins
    set_sense(3, SENSE_FALL);
    set_sense(6, SENSE_FALL);
    set_prio(6, 3);
    set_prio(3, 1);
    irq[3] = 1'b0; irq[6] = 1'b0;
    push(22); push(19);
    service("R5 level 3 first");
    service("R5 level 1 second");
    irq[3] = 1'b1; irq[6] = 1'b1;
    step(4);

    // R5 tie goes to lower number
    set_sense(1, SENSE_FALL);
    set_prio(1, 2);
    set_prio(6, 2);
    irq[1] = 1'b0; irq[6] = 1'b0;
    push(17); push(22);
    service("R5 tie lower line first");
    service("R5 tie second");
    irq[1] = 1'b1; irq[6] = 1'b1;
    step(4);

    // R6 non-maskable with all lines disabled
    ctrl_v[7:0] = 8'h00;
    wr(ADDR_CTRL, ctrl_v);
    nmi = 1'b0;
    push(7);
    service("R6 nmi falling unmasked");
    ctrl_v[8] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    nmi = 1'b1;
    push(7);
    service("R6 nmi rising select");
    nmi = 1'b0;
    step(6);
    chk("R6 rising select ignores fall", int'(req), 0);

    // R6 nmi beats top-level line 7
    ctrl_v[7] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    set_sense(7, SENSE_FALL);
    set_prio(7, 3);
    nmi = 1'b1; irq[7] = 1'b0;
    push(7); push(23);
    service("R6 nmi over line7");
    service("R6 line7 after nmi");
    irq[7] = 1'b1;
    step(4);

    // R8 wake gating
    ctrl_v[5] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    set_sense(5, SENSE_FALL);
    irq[5] = 1'b0;
    step(3);
    chk("R8 line5 no wake without select", int'(wake), 0);
    ctrl_v[9] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    chk("R8 line5 wakes with select", int'(wake), 1);
    push(21);
    service("R8 line5 service");
    chk("R8 wake low after clear", int'(wake), 0);
    irq[5] = 1'b1;
    ctrl_v[9] = 1'b0;
    ctrl_v[2] = 1'b1;
    wr(ADDR_CTRL, ctrl_v);
    irq[2] = 1'b0;
    step(3);
    chk("R8 line2 wakes without select", int'(wake), 1);
    push(18);
    service("R8 line2 service");
    irq[2] = 1'b1;
    step(4);

    chk("R7 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule